// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside a frame receiver and decides, for each incoming frame, what kind of destination address it carries and whether the frame should be kept. When the receiver has the destination address of a frame, it pulses a strobe and presents several things in the same cycle: the 48-bit address, the low bits of the frame's CRC (used as the multicast hash index), an error flag and the frame length. One clock later the block reports three results: a 3-bit destination type code, an accept flag and a length that optionally counts the four CRC bytes.

The accept decision is set by the receive enable, a set of accept-enable bits, the station's own address and a 64-entry multicast hash table. These settings form a ladder of modes, and each mode adds to the one below it. With receive off, nothing is accepted. With receive on and no accept bits set, only the station's own frames are accepted. The next rungs add broadcast, then hashed multicast, then all multicast (hash table all ones), then every good frame (promiscuous), and at the top also frames marked in error.

The input side is a valid-only stream with no back-pressure: the block takes a new address on every cycle in which the strobe is high, so strobes may arrive back to back. The result side is also valid-only. The downstream consumer must take each result in the cycle in which its valid is high.

Top module: `rxf_addr_filter`

## Requirements
- R1: A result appears with `res_valid` high exactly one clock after each cycle with `da_valid` high, and `res_valid` is low otherwise; between strobes `res_type`, `res_accept` and `res_len` hold their values. After reset `res_valid` and `res_accept` are 0.
- R2: An address of all ones (broadcast) gives `res_type` = 3'b011.
- R3: A non-broadcast address with bit 40 of `da_addr` set (the least significant bit of the first byte, bits 47:40) is multicast. Such an address gives 3'b110 when `hash_tbl[crc_low]` is 1 and 3'b010 when it is 0.
- R4: An address with bit 40 clear is physical. It gives 3'b001 when it equals `station_addr` and 3'b000 otherwise.
- R5: While `rx_en` is 0, `res_accept` is 0, but `res_type` is still reported.
- R6: A frame with `frame_err` high is dropped unless `acc_err` is 1. With `acc_err` = 1, the error flag has no effect on the decision.
- R7: With `rx_en` = 1, a frame of type 3'b001 (own station) that the error rule does not drop is accepted regardless of the accept bits.
- R8: Broadcast is accepted when `acc_bc` is 1, and a multicast hash hit is accepted when `acc_mc` is 1. A multicast hash miss or a foreign physical address is accepted only in promiscuous mode.
- R9: With `acc_phy` = 1 (promiscuous), every frame type is accepted, subject to R5 and R6.
- R10: With `keep_crc` = 1, `res_len` is `frame_len` + 4, saturating at 8191. With `keep_crc` = 0, `res_len` equals `frame_len`. Both lengths are 13 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da_addr | input | 48 | Destination address, first byte in bits 47:40 |
| crc_low | input | 6 | Low CRC bits, used as the hash table index |
| frame_err | input | 1 | Frame was received with an error |
| frame_len | input | 13 | Frame length in bytes, without CRC |
| station_addr | input | 48 | This station's physical address |
| hash_tbl | input | 64 | Multicast hash table, one bit per index |
| rx_en | input | 1 | Receive enable |
| acc_err | input | 1 | Accept frames marked in error |
| acc_mc | input | 1 | Accept multicast frames that hit the hash |
| acc_bc | input | 1 | Accept broadcast frames |
| acc_phy | input | 1 | Promiscuous: accept every frame |
| keep_crc | input | 1 | Report the length with the CRC bytes included |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_type | output | 3 | Destination type code |
| res_accept | output | 1 | Frame is to be kept |
| res_len | output | 13 | Reported frame length |

## Verification
On every cycle, the assertions check the following: the result valid tracks the strobe one clock later, outputs hold between strobes, nothing is accepted with receive off, errored frames are dropped without error acceptance, broadcast is classified as such, own-station frames are accepted, and the length passes through unchanged without keep-CRC. Only the bench's scenarios can show the full accept-mode ladder. They sweep every rung against own, foreign, broadcast, hash-hit, hash-miss and errored frames, and they also cover hash lookup at specific indices and the saturating CRC length at the top of the 13-bit range.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Destination classification codes. The encodings are the block's output contract.
  typedef enum logic [2:0] {
    DT_PHYS_MISS = 3'b000,
    DT_PHYS_HIT  = 3'b001,
    DT_MC_MISS   = 3'b010,
    DT_BCAST     = 3'b011,
    DT_MC_HIT    = 3'b110
  } dest_type_e;

  // Accept-enable settings, gathered together.
  typedef struct packed {
    logic rx_en;
    logic acc_err;
    logic acc_mc;
    logic acc_bc;
    logic acc_phy;
  } accept_cfg_t;

endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned HASH_BITS = 6
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ADDR_W-1:0]           station,
  input  logic [HASH_BITS-1:0]        hash_idx,
  input  logic [(1<<HASH_BITS)-1:0]   hash_tbl,
  output dest_type_e                  dtype
);
  // Group bit sits in the LSB of the first transmitted byte (top byte here).
  localparam int unsigned MC_BIT = ADDR_W - 8;

  logic is_bcast, is_group, hash_hit, is_own;

  always_comb begin
    is_bcast = &addr;
    is_group = addr[MC_BIT];
    hash_hit = hash_tbl[hash_idx];
    is_own   = (addr == station);
    if (is_bcast)      dtype = DT_BCAST;
    else if (is_group) dtype = hash_hit ? DT_MC_HIT : DT_MC_MISS;
    else               dtype = is_own ? DT_PHYS_HIT : DT_PHYS_MISS;
  end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  dest_type_e  dtype,
  input  logic        frame_err,
  input  accept_cfg_t cfg,
  output logic        accept
);
  logic class_ok, err_ok;

  always_comb begin
    unique case (dtype)
      DT_PHYS_HIT: class_ok = 1'b1;
      DT_BCAST:    class_ok = cfg.acc_bc | cfg.acc_phy;
      DT_MC_HIT:   class_ok = cfg.acc_mc | cfg.acc_phy;
      default:     class_ok = cfg.acc_phy;
    endcase
    err_ok = ~frame_err | cfg.acc_err;
    accept = cfg.rx_en & err_ok & class_ok;
  end

endmodule

// File: rtl/rxf_len_adj.sv
module rxf_len_adj #(
  parameter int unsigned LEN_W     = 13,
  parameter int unsigned CRC_BYTES = 4
) (
  input  logic [LEN_W-1:0] len_in,
  input  logic             keep_crc,
  output logic [LEN_W-1:0] len_out
);
  localparam logic [LEN_W:0] ADD = (LEN_W+1)'(CRC_BYTES);

  logic [LEN_W:0] sum;

  always_comb begin
    sum = {1'b0, len_in} + ADD;
    if (!keep_crc)       len_out = len_in;
    else if (sum[LEN_W]) len_out = '1;
    else                 len_out = sum[LEN_W-1:0];
  end

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned HASH_BITS = 6,
  parameter int unsigned LEN_W     = 13,
  parameter int unsigned CRC_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        da_valid,
  input  logic [ADDR_W-1:0]           da_addr,
  input  logic [HASH_BITS-1:0]        crc_low,
  input  logic                        frame_err,
  input  logic [LEN_W-1:0]            frame_len,
  input  logic [ADDR_W-1:0]           station_addr,
  input  logic [(1<<HASH_BITS)-1:0]   hash_tbl,
  input  logic                        rx_en,
  input  logic                        acc_err,
  input  logic                        acc_mc,
  input  logic                        acc_bc,
  input  logic                        acc_phy,
  input  logic                        keep_crc,
  output logic                        res_valid,
  output logic [2:0]                  res_type,
  output logic                        res_accept,
  output logic [LEN_W-1:0]            res_len
);
  dest_type_e       dtype_c;
  logic             accept_c;
  logic [LEN_W-1:0] len_c;
  accept_cfg_t      cfg;

  assign cfg = '{rx_en: rx_en, acc_err: acc_err, acc_mc: acc_mc,
                 acc_bc: acc_bc, acc_phy: acc_phy};

  rxf_classify #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_class (
    .addr    (da_addr),
    .station (station_addr),
    .hash_idx(crc_low),
    .hash_tbl(hash_tbl),
    .dtype   (dtype_c)
  );

  rxf_decide u_decide (
    .dtype    (dtype_c),
    .frame_err(frame_err),
    .cfg      (cfg),
    .accept   (accept_c)
  );

  rxf_len_adj #(.LEN_W(LEN_W), .CRC_BYTES(CRC_BYTES)) u_len (
    .len_in  (frame_len),
    .keep_crc(keep_crc),
    .len_out (len_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_type   <= DT_PHYS_MISS;
      res_accept <= 1'b0;
      res_len    <= '0;
    end else begin
      res_valid <= da_valid;
      if (da_valid) begin
        res_type   <= dtype_c;
        res_accept <= accept_c;
        res_len    <= len_c;
      end
    end
  end

endmodule

// File: rtl/rxf_addr_filter_chk.sv
module rxf_addr_filter_chk #(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned LEN_W     = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              da_valid,
  input logic [ADDR_W-1:0] da_addr,
  input logic              frame_err,
  input logic [LEN_W-1:0]  frame_len,
  input logic [ADDR_W-1:0] station_addr,
  input logic              rx_en,
  input logic              acc_err,
  input logic              keep_crc,
  input logic              res_valid,
  input logic [2:0]        res_type,
  input logic              res_accept,
  input logic [LEN_W-1:0]  res_len
);
  localparam int unsigned MC_BIT = ADDR_W - 8;

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ($stable(res_type) && $stable(res_accept) && $stable(res_len)));
  p_bcast_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da_addr)) |=> (res_type == 3'b011));
  p_rx_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !rx_en) |=> !res_accept);
  p_err_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && frame_err && !acc_err) |=> !res_accept);
  p_own_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && rx_en && !frame_err && !da_addr[MC_BIT] && da_addr == station_addr)
      |=> (res_accept && res_type == 3'b001));
  p_len_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !keep_crc) |=> (res_len == $past(frame_len)));

endmodule

bind rxf_addr_filter rxf_addr_filter_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_rxf_addr_filter.sv
`timescale 1ns/1ps
module tb_rxf_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic [5:0]  crc_low = '0;
  logic        frame_err = 1'b0;
  logic [12:0] frame_len = '0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic [63:0] hash_tbl = '0;
  logic        rx_en = 1'b0, acc_err = 1'b0, acc_mc = 1'b0, acc_bc = 1'b0, acc_phy = 1'b0;
  logic        keep_crc = 1'b0;
  logic        res_valid, res_accept;
  logic [2:0]  res_type;
  logic [12:0] res_len;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  localparam logic [47:0] A_OWN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] A_OTHER = 48'h02_11_22_33_44_66;
  localparam logic [47:0] A_BC    = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] A_MC    = 48'h01_00_5E_00_00_01;
  localparam logic [63:0] H_PART  = 64'h0000_0000_0000_0100; // only index 8 set

  always #5 clk = ~clk;

  rxf_addr_filter dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input logic [5:0] c, input logic e,
                      input logic [12:0] l);
    @(negedge clk);
    da_addr = a; crc_low = c; frame_err = e; frame_len = l; da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  // Expected type code, from R2/R3/R4.
  function automatic logic [2:0] exp_type(input logic [47:0] a, input logic [5:0] c);
    if (a == 48'hFFFF_FFFF_FFFF) return 3'b011;
    if (a[40])                   return hash_tbl[c] ? 3'b110 : 3'b010;
    return (a == station_addr) ? 3'b001 : 3'b000;
  endfunction

  // Expected accept, from R5..R9.
  function automatic logic exp_acc(input logic [2:0] t, input logic e);
    if (!rx_en)           return 1'b0;
    if (e && !acc_err)    return 1'b0;
    if (acc_phy)          return 1'b1;
    case (t)
      3'b001:  return 1'b1;
      3'b011:  return acc_bc;
      3'b110:  return acc_mc;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_mode(input int m);
    rx_en   = (m >= 1);
    acc_bc  = (m >= 2);
    acc_mc  = (m >= 3);
    hash_tbl = (m >= 4) ? '1 : H_PART;
    acc_phy = (m >= 5);
    acc_err = (m >= 6);
  endtask

  task automatic t_reset;
    chk("R1 reset res_valid", res_valid, 0);
    chk("R1 reset res_accept", res_accept, 0);
  endtask

  // Ladder sweep: R2, R3, R4, R5, R6, R7, R8, R9.
  task automatic t_ladder;
    logic [47:0] a; logic [5:0] c; logic e;
    for (int m = 0; m < 7; m++) begin
      @(negedge clk); set_mode(m);
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: begin a = A_OWN;   c = 6'd3; e = 1'b0; end
          1: begin a = A_OTHER; c = 6'd3; e = 1'b0; end
          2: begin a = A_BC;    c = 6'd3; e = 1'b0; end
          3: begin a = A_MC;    c = 6'd8; e = 1'b0; end
          4: begin a = A_MC;    c = 6'd9; e = 1'b0; end
          default: begin a = A_OWN; c = 6'd3; e = 1'b1; end
        endcase
        send(a, c, e, 13'd64);
        chk($sformatf("R1 valid mode%0d kind%0d", m, k), res_valid, 1);
        chk($sformatf("R2/R3/R4 type mode%0d kind%0d", m, k), res_type, exp_type(a, c));
        chk($sformatf("R7/R8/R9 accept mode%0d kind%0d", m, k), res_accept,
            exp_acc(exp_type(a, c), e));
      end
    end
  endtask

  task automatic t_rx_off;
    @(negedge clk); set_mode(6); rx_en = 1'b0;
    send(A_BC, 6'd0, 1'b0, 13'd70);
    chk("R5 type kept with rx off", res_type, 3'b011);
    chk("R5 accept forced low", res_accept, 0);
  endtask

  task automatic t_errors;
    @(negedge clk); set_mode(5);
    send(A_BC, 6'd0, 1'b1, 13'd70);
    chk("R6 errored bcast dropped", res_accept, 0);
    @(negedge clk); acc_err = 1'b1;
    send(A_BC, 6'd0, 1'b1, 13'd70);
    chk("R6 errored bcast kept", res_accept, 1);
  endtask

  task automatic t_hash_index;
    @(negedge clk); set_mode(3); hash_tbl = 64'h8000_0000_0000_0001;
    send(A_MC, 6'd63, 1'b0, 13'd80);
    chk("R3 hash index 63 hit", res_type, 3'b110);
    send(A_MC, 6'd0, 1'b0, 13'd80);
    chk("R3 hash index 0 hit", res_type, 3'b110);
    send(A_MC, 6'd62, 1'b0, 13'd80);
    chk("R3 hash index 62 miss", res_type, 3'b010);
    chk("R8 hash miss dropped", res_accept, 0);
  endtask

  task automatic t_len;
    @(negedge clk); set_mode(1); keep_crc = 1'b1;
    send(A_OWN, 6'd0, 1'b0, 13'd60);
    chk("R10 keep crc 60", res_len, 64);
    send(A_OWN, 6'd0, 1'b0, 13'd8190);
    chk("R10 saturate 8190", res_len, 8191);
    send(A_OWN, 6'd0, 1'b0, 13'd8191);
    chk("R10 saturate 8191", res_len, 8191);
    @(negedge clk); keep_crc = 1'b0;
    send(A_OWN, 6'd0, 1'b0, 13'd100);
    chk("R10 plain length", res_len, 100);
  endtask

  task automatic t_hold;
    @(negedge clk); set_mode(2);
    send(A_BC, 6'd0, 1'b0, 13'd90);
    @(negedge clk);
    chk("R1 valid drops", res_valid, 0);
    da_addr = A_OTHER; frame_len = 13'd5;
    @(negedge clk);
    chk("R1 type held", res_type, 3'b011);
    chk("R1 accept held", res_accept, 1);
    chk("R1 len held", res_len, 90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ladder;
    t_rx_off;
    t_errors;
    t_hash_index;
    t_len;
    t_hold;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule